// File: doc/BRIEF.md
# Memory Dependence Wakeup Tracker

This block tracks the loads, stores and barriers that are in flight in an out-of-order core. Each tracked instruction has a sequence number, and the block decides when that instruction may go to memory. When an instruction is inserted, the block looks for the older store or barrier it has to wait behind. That producer normally comes from an external store-set predictor, which supplies a sequence number on a port. The block replaces that prediction while a barrier is open. An instruction is presented on a single release port only once its source registers are ready and its memory dependence has resolved.

The block works from one command per cycle: insert, registers-ready, non-speculative-ready, complete, reschedule, replay or squash. Each command names its target by sequence number. Completing a store or barrier wakes every entry linked to it. A squash discards everything younger than a given sequence number. Rescheduled instructions wait in a replay set until a replay command releases all of them together.

Each entry records the index of its producer, not a list of its dependents. Wakeup is therefore one parallel match across the table. The block assumes a single thread and sequence numbers that do not wrap while they are in flight.

Top module: `mdep_tracker`

## Requirements
- R1: Inserting a full barrier (kind 2) opens both the load block and the store block under its sequence number. Inserting a write barrier (kind 3) opens only the store block. A write barrier leaves loads (kind 0) unaffected.
- R2: An insert is command 1. On insert, a load takes the load-block sequence number as its producer while that block is open. A store (kind 1) takes the store-block sequence number while that block is open. Otherwise the instruction takes `pred_seq_i`, and a value of 0 means there is no producer.
- R3: If the chosen producer is 0, or matches no live entry, the new entry is memory-ready at once. If it is inserted with `regs_rdy_i` high, it appears on the release port in the cycle after the insert.
- R4: An entry is released only when it is both register-ready and memory-ready. The registers-ready command (2) on a memory-ready entry releases it in the next cycle.
- R5: The complete command (4) frees the target entry. When the target is a store or a barrier, each entry linked to it becomes memory-ready, and each linked entry that is register-ready is released. Completing a load wakes nothing.
- R6: Completing a barrier closes the load block or the store block only when the sequence number recorded in that block equals the barrier's own. A newer barrier therefore stays in force.
- R7: The squash command (7) with sequence number S removes every entry, and every replay-set member, whose sequence number is greater than S. Entries with a sequence number at or below S are untouched.
- R8: The reschedule command (5) adds an entry to the replay set. The replay command (6) releases every member of the set and empties it. The entry it names must be a member.
- R9: An insert with `nonspec_i` high performs no dependence check, and neither registers-ready nor a wakeup releases it. Only the non-speculative-ready command (3) releases it.
- R10: `full_o` is high when every entry is occupied. An insert while the table is full is refused, and the table is left unchanged.
- R11: At most one entry is released per cycle. Among the pending entries, the one with the smallest sequence number goes first, whatever its table position. A released entry is not presented again unless it is released anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command: 0 none, 1 insert, 2 registers-ready, 3 non-speculative-ready, 4 complete, 5 reschedule, 6 replay, 7 squash |
| kind_i | input | 2 | Kind on insert: 0 load, 1 store, 2 full barrier, 3 write barrier |
| seq_i | input | SEQ_W | Sequence number of the command's target, or the squash bound |
| pred_seq_i | input | SEQ_W | Predicted producing-store sequence number, 0 for none |
| regs_rdy_i | input | 1 | On insert, the source registers are already ready |
| nonspec_i | input | 1 | On insert, the entry is non-speculative |
| full_o | output | 1 | All entries are occupied |
| rel_valid_o | output | 1 | An entry is released this cycle |
| rel_seq_o | output | SEQ_W | Sequence number of the released entry |

## Verification
The bench uses the default table depth of eight entries and 16-bit sequence numbers. With eight entries, the directed scenarios can fill the table completely and show that an insert is refused when it is full. They can also free a low slot and reuse it for a younger store. Oldest-first release can then be told apart from lowest-slot release. Several barriers stay open together, so a newer full barrier can be shown to outlast the completion of an older write barrier.

// File: rtl/mdep_pkg.sv
package mdep_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_INS     = 3'd1,
    CMD_REGS    = 3'd2,
    CMD_NSRDY   = 3'd3,
    CMD_DONE    = 3'd4,
    CMD_RESCHED = 3'd5,
    CMD_REPLAY  = 3'd6,
    CMD_SQUASH  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    K_LOAD  = 2'd0,
    K_STORE = 2'd1,
    K_MBAR  = 2'd2,
    K_WBAR  = 2'd3
  } kind_e;
endpackage

// File: rtl/mdep_seq_match.sv
module mdep_seq_match #(
  parameter int unsigned N     = 8,
  parameter int unsigned SEQ_W = 16
) (
  input  logic [N-1:0]     valid_i,
  input  logic [SEQ_W-1:0] seq_i [N],
  input  logic [SEQ_W-1:0] key_i,
  output logic [N-1:0]     hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (seq_i[g] == key_i);
  end
endmodule

// File: rtl/mdep_prio.sv
module mdep_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdep_oldest.sv
module mdep_oldest #(
  parameter int unsigned N     = 8,
  parameter int unsigned SEQ_W = 16
) (
  input  logic [N-1:0]     req_i,
  input  logic [SEQ_W-1:0] seq_i [N],
  output logic [N-1:0]     grant_o,
  output logic             valid_o,
  output logic [SEQ_W-1:0] seq_o
);
  int unsigned best;

  always_comb begin
    best    = 0;
    valid_o = 1'b0;
    seq_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!valid_o || seq_i[i] < seq_o)) begin
        best    = i;
        valid_o = 1'b1;
        seq_o   = seq_i[i];
      end
    end
    grant_o = '0;
    if (valid_o) grant_o[best] = 1'b1;
  end
endmodule

// File: rtl/mdep_barrier.sv
module mdep_barrier #(
  parameter int unsigned SEQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_mbar_i,
  input  logic             set_wbar_i,
  input  logic             done_mbar_i,
  input  logic             done_wbar_i,
  input  logic [SEQ_W-1:0] seq_i,
  output logic             ld_blk_o,
  output logic [SEQ_W-1:0] ld_sn_o,
  output logic             st_blk_o,
  output logic [SEQ_W-1:0] st_sn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_blk_o <= 1'b0;
      st_blk_o <= 1'b0;
      ld_sn_o  <= '0;
      st_sn_o  <= '0;
    end else begin
      if (set_mbar_i) begin
        ld_blk_o <= 1'b1;
        ld_sn_o  <= seq_i;
        st_blk_o <= 1'b1;
        st_sn_o  <= seq_i;
      end else if (set_wbar_i) begin
        st_blk_o <= 1'b1;
        st_sn_o  <= seq_i;
      end else if (done_mbar_i) begin
        if (ld_sn_o == seq_i) ld_blk_o <= 1'b0;
        if (st_sn_o == seq_i) st_blk_o <= 1'b0;
      end else if (done_wbar_i) begin
        if (st_sn_o == seq_i) st_blk_o <= 1'b0;
      end
    end
  end

  p_mbar_sets_both_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_mbar_i |=> ld_blk_o && st_blk_o && ld_sn_o == $past(seq_i) && st_sn_o == $past(seq_i));

  p_wbar_keeps_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wbar_i && !set_mbar_i |=> $stable(ld_blk_o) && $stable(ld_sn_o));

  p_newer_barrier_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_mbar_i || done_wbar_i) && !set_mbar_i && !set_wbar_i && st_blk_o && st_sn_o != seq_i
      |=> st_blk_o);
endmodule

// File: rtl/mdep_tracker.sv
module mdep_tracker
  import mdep_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SEQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cmd_i,
  input  logic [1:0]       kind_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [SEQ_W-1:0] pred_seq_i,
  input  logic             regs_rdy_i,
  input  logic             nonspec_i,
  output logic             full_o,
  output logic             rel_valid_o,
  output logic [SEQ_W-1:0] rel_seq_o
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  cmd_e  cmd;
  kind_e kind;
  assign cmd  = cmd_e'(cmd_i);
  assign kind = kind_e'(kind_i);

  logic [DEPTH-1:0] valid_q, regs_q, mem_q, pend_q, link_q, rq_q, nspec_q;
  logic [SEQ_W-1:0] seq_q      [DEPTH];
  kind_e            kind_q     [DEPTH];
  logic [IW-1:0]    link_idx_q [DEPTH];

  // target and producer lookup
  logic [DEPTH-1:0] tgt_hit, prod_hit, younger;
  logic [IW-1:0]    tgt_idx, prod_idx, free_idx;
  logic             tgt_any, prod_any, free_any;
  logic [SEQ_W-1:0] prod_key;
  logic             prod_ok;

  logic             ld_blk, st_blk;
  logic [SEQ_W-1:0] ld_sn, st_sn;

  always_comb begin
    if (kind == K_LOAD && ld_blk)       prod_key = ld_sn;
    else if (kind == K_STORE && st_blk) prod_key = st_sn;
    else                                prod_key = pred_seq_i;
  end

  mdep_seq_match #(.N(DEPTH), .SEQ_W(SEQ_W)) u_tgt_cam (
    .valid_i(valid_q), .seq_i(seq_q), .key_i(seq_i), .hit_o(tgt_hit)
  );

  mdep_seq_match #(.N(DEPTH), .SEQ_W(SEQ_W)) u_prod_cam (
    .valid_i(valid_q), .seq_i(seq_q), .key_i(prod_key), .hit_o(prod_hit)
  );

  mdep_prio #(.N(DEPTH), .IW(IW)) u_tgt_pick (
    .req_i(tgt_hit), .idx_o(tgt_idx), .any_o(tgt_any)
  );

  mdep_prio #(.N(DEPTH), .IW(IW)) u_prod_pick (
    .req_i(prod_hit), .idx_o(prod_idx), .any_o(prod_any)
  );

  mdep_prio #(.N(DEPTH), .IW(IW)) u_free_pick (
    .req_i(~valid_q), .idx_o(free_idx), .any_o(free_any)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    assign younger[g] = valid_q[g] && (seq_q[g] > seq_i);
  end

  assign full_o  = ~free_any;
  assign prod_ok = prod_any && (prod_key != '0);

  logic ins_ok, ins_bar, done_hit, done_wakes;
  kind_e tgt_kind;

  assign ins_ok     = (cmd == CMD_INS) && free_any;
  assign ins_bar    = (kind == K_MBAR) || (kind == K_WBAR);
  assign tgt_kind   = kind_q[tgt_idx];
  assign done_hit   = (cmd == CMD_DONE) && tgt_any;
  assign done_wakes = done_hit && (tgt_kind != K_LOAD);

  mdep_barrier #(.SEQ_W(SEQ_W)) u_barrier (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_mbar_i (ins_ok && kind == K_MBAR),
    .set_wbar_i (ins_ok && kind == K_WBAR),
    .done_mbar_i(done_hit && tgt_kind == K_MBAR),
    .done_wbar_i(done_hit && tgt_kind == K_WBAR),
    .seq_i      (seq_i),
    .ld_blk_o   (ld_blk),
    .ld_sn_o    (ld_sn),
    .st_blk_o   (st_blk),
    .st_sn_o    (st_sn)
  );

  // release selection
  logic [DEPTH-1:0] grant;

  mdep_oldest #(.N(DEPTH), .SEQ_W(SEQ_W)) u_oldest (
    .req_i  (pend_q),
    .seq_i  (seq_q),
    .grant_o(grant),
    .valid_o(rel_valid_o),
    .seq_o  (rel_seq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      regs_q  <= '0;
      mem_q   <= '0;
      pend_q  <= '0;
      link_q  <= '0;
      rq_q    <= '0;
      nspec_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        seq_q[i]      <= '0;
        kind_q[i]     <= K_LOAD;
        link_idx_q[i] <= '0;
      end
    end else begin
      pend_q <= pend_q & ~grant;
      unique case (cmd)
        CMD_INS: if (ins_ok) begin
          valid_q[free_idx] <= 1'b1;
          seq_q[free_idx]   <= seq_i;
          kind_q[free_idx]  <= kind;
          regs_q[free_idx]  <= regs_rdy_i;
          nspec_q[free_idx] <= nonspec_i;
          rq_q[free_idx]    <= 1'b0;
          link_idx_q[free_idx] <= prod_idx;
          if (nonspec_i || ins_bar) begin
            mem_q[free_idx]  <= 1'b0;
            link_q[free_idx] <= 1'b0;
            pend_q[free_idx] <= 1'b0;
          end else if (prod_ok) begin
            mem_q[free_idx]  <= 1'b0;
            link_q[free_idx] <= 1'b1;
            pend_q[free_idx] <= 1'b0;
          end else begin
            mem_q[free_idx]  <= 1'b1;
            link_q[free_idx] <= 1'b0;
            pend_q[free_idx] <= regs_rdy_i;
          end
        end
        CMD_REGS: if (tgt_any) begin
          regs_q[tgt_idx] <= 1'b1;
          if (mem_q[tgt_idx] && !nspec_q[tgt_idx]) pend_q[tgt_idx] <= 1'b1;
        end
        CMD_NSRDY: if (tgt_any) begin
          regs_q[tgt_idx] <= 1'b1;
          mem_q[tgt_idx]  <= 1'b1;
          pend_q[tgt_idx] <= 1'b1;
        end
        CMD_DONE: if (tgt_any) begin
          valid_q[tgt_idx] <= 1'b0;
          pend_q[tgt_idx]  <= 1'b0;
          rq_q[tgt_idx]    <= 1'b0;
          link_q[tgt_idx]  <= 1'b0;
          for (int i = 0; i < DEPTH; i++) begin
            if (valid_q[i] && link_q[i] && link_idx_q[i] == tgt_idx && IW'(i) != tgt_idx) begin
              link_q[i] <= 1'b0;
              if (done_wakes) begin
                mem_q[i] <= 1'b1;
                if (regs_q[i] && !nspec_q[i]) pend_q[i] <= 1'b1;
              end
            end
          end
        end
        CMD_RESCHED: if (tgt_any) rq_q[tgt_idx] <= 1'b1;
        CMD_REPLAY: begin
          pend_q <= (pend_q & ~grant) | rq_q;
          rq_q   <= '0;
        end
        CMD_SQUASH: begin
          valid_q <= valid_q & ~younger;
          pend_q  <= pend_q & ~grant & ~younger;
          rq_q    <= rq_q & ~younger;
          link_q  <= link_q & ~younger;
        end
        default: ;
      endcase
    end
  end

  p_one_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_INS && full_o |=> $stable(valid_q));

  p_replay_member_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_REPLAY |-> |(rq_q & tgt_hit));

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    p_release_both_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q[g] |-> valid_q[g] && regs_q[g] && mem_q[g]);

    p_squash_young_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd == CMD_SQUASH && valid_q[g] && seq_q[g] > seq_i |=> !valid_q[g]);

    p_squash_old_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd == CMD_SQUASH && valid_q[g] && seq_q[g] <= seq_i |=> valid_q[g]);
  end
endmodule

// File: tb/mdep_tracker_test.sv
module mdep_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  kind = 2'd0;
  logic [15:0] seq = '0;
  logic [15:0] pred = '0;
  logic        regs = 1'b0;
  logic        nspec = 1'b0;
  logic        full;
  logic        rel_v;
  logic [15:0] rel_s;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mdep_tracker #(.DEPTH(8), .SEQ_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .kind_i(kind), .seq_i(seq),
    .pred_seq_i(pred), .regs_rdy_i(regs), .nonspec_i(nspec),
    .full_o(full), .rel_valid_o(rel_v), .rel_seq_o(rel_s)
  );

  // drive at a negedge, return at the next negedge with the effect visible
  task automatic issue(input logic [2:0] c, input logic [1:0] k, input int s,
                       input int p, input logic r, input logic n);
    cmd = c; kind = k; seq = 16'(s); pred = 16'(p); regs = r; nspec = n;
    @(negedge clk);
    cmd = 3'd0; regs = 1'b0; nspec = 1'b0;
  endtask

  task automatic ins(input logic [1:0] k, input int s, input int p, input logic r);
    issue(3'd1, k, s, p, r, 1'b0);
  endtask

  task automatic op(input logic [2:0] c, input int s);
    issue(c, 2'd0, s, 0, 1'b0, 1'b0);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_rel(input string req, input logic v, input int s);
    total++;
    if (rel_v !== v || (v && rel_s !== 16'(s))) begin
      bad++;
      $display("FAIL %s: release valid=%0b seq=%0d, expected valid=%0b seq=%0d",
               req, rel_v, rel_s, v, s);
    end
  endtask

  task automatic expect_full(input string req, input logic v);
    total++;
    if (full !== v) begin
      bad++;
      $display("FAIL %s: full=%0b, expected %0b", req, full, v);
    end
  endtask

  task automatic t_reset();
    expect_rel("reset", 1'b0, 0);
    expect_full("reset", 1'b0);
  endtask

  task automatic t_direct_release();
    ins(2'd0, 10, 0, 1'b1); expect_rel("R3", 1'b1, 10);
    tick();                 expect_rel("R11", 1'b0, 0);
    op(3'd4, 10);
    ins(2'd0, 11, 0, 1'b0); expect_rel("R4", 1'b0, 0);
    op(3'd2, 11);           expect_rel("R4", 1'b1, 11);
    op(3'd4, 11);
    ins(2'd0, 23, 99, 1'b1); expect_rel("R3", 1'b1, 23);
    op(3'd4, 23);
  endtask

  task automatic t_store_wakeup();
    ins(2'd1, 20, 0, 1'b1);  expect_rel("R3", 1'b1, 20);
    ins(2'd0, 21, 20, 1'b1); expect_rel("R2", 1'b0, 0);
    ins(2'd0, 22, 20, 1'b0); expect_rel("R2", 1'b0, 0);
    op(3'd4, 20);            expect_rel("R5", 1'b1, 21);
    tick();                  expect_rel("R5", 1'b0, 0);
    op(3'd2, 22);            expect_rel("R5", 1'b1, 22);
    op(3'd4, 21);
    op(3'd4, 22);
    ins(2'd0, 60, 0, 1'b1);  expect_rel("R3", 1'b1, 60);
    ins(2'd0, 61, 60, 1'b1); expect_rel("R2", 1'b0, 0);
    op(3'd4, 60);            expect_rel("R5", 1'b0, 0);
    op(3'd7, 59);
  endtask

  task automatic t_barriers();
    ins(2'd3, 30, 0, 1'b0);
    ins(2'd0, 31, 0, 1'b1);  expect_rel("R1", 1'b1, 31);
    ins(2'd1, 32, 0, 1'b1);  expect_rel("R1", 1'b0, 0);
    ins(2'd2, 33, 0, 1'b0);
    ins(2'd0, 34, 0, 1'b1);  expect_rel("R2", 1'b0, 0);
    ins(2'd1, 35, 0, 1'b1);  expect_rel("R2", 1'b0, 0);
    op(3'd4, 30);            expect_rel("R5", 1'b1, 32);
    ins(2'd1, 36, 0, 1'b1);  expect_rel("R6", 1'b0, 0);
    op(3'd4, 33);            expect_rel("R11", 1'b1, 34);
    tick();                  expect_rel("R11", 1'b1, 35);
    tick();                  expect_rel("R11", 1'b1, 36);
    tick();                  expect_rel("R11", 1'b0, 0);
    ins(2'd0, 37, 0, 1'b1);  expect_rel("R6", 1'b1, 37);
    ins(2'd1, 38, 0, 1'b1);  expect_rel("R6", 1'b1, 38);
    op(3'd7, 29);
    tick();
  endtask

  task automatic t_nonspec();
    issue(3'd1, 2'd0, 40, 0, 1'b1, 1'b1); expect_rel("R9", 1'b0, 0);
    op(3'd2, 40);                         expect_rel("R9", 1'b0, 0);
    op(3'd3, 40);                         expect_rel("R9", 1'b1, 40);
    op(3'd7, 39);
  endtask

  task automatic t_replay_squash();
    ins(2'd0, 50, 0, 1'b1); expect_rel("R3", 1'b1, 50);
    ins(2'd0, 51, 0, 1'b1); expect_rel("R3", 1'b1, 51);
    op(3'd5, 51);           expect_rel("R8", 1'b0, 0);
    op(3'd5, 50);
    op(3'd6, 51);           expect_rel("R8", 1'b1, 50);
    tick();                 expect_rel("R8", 1'b1, 51);
    tick();                 expect_rel("R8", 1'b0, 0);
    ins(2'd0, 52, 0, 1'b0);
    op(3'd5, 51);
    op(3'd7, 50);
    op(3'd2, 52);           expect_rel("R7", 1'b0, 0);
    op(3'd5, 50);
    op(3'd6, 50);           expect_rel("R7", 1'b1, 50);
    tick();                 expect_rel("R7", 1'b0, 0);
  endtask

  task automatic t_full();
    for (int i = 101; i <= 107; i++) ins(2'd0, i, 0, 1'b0);
    expect_full("R10", 1'b1);
    ins(2'd0, 108, 0, 1'b1); expect_rel("R10", 1'b0, 0);
    op(3'd2, 108);           expect_rel("R10", 1'b0, 0);
    op(3'd7, 100);           expect_full("R10", 1'b0);
    op(3'd2, 50);            expect_rel("R7", 1'b1, 50);
    op(3'd7, 49);
  endtask

  task automatic t_age_order();
    ins(2'd0, 85, 0, 1'b0);
    ins(2'd3, 86, 0, 1'b0);
    ins(2'd1, 87, 0, 1'b1);
    op(3'd4, 85);           expect_rel("R5", 1'b0, 0);
    ins(2'd1, 88, 0, 1'b1); expect_rel("R2", 1'b0, 0);
    op(3'd4, 86);           expect_rel("R11", 1'b1, 87);
    tick();                 expect_rel("R11", 1'b1, 88);
    tick();                 expect_rel("R11", 1'b0, 0);
    op(3'd7, 84);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct_release();
    t_store_wakeup();
    t_barriers();
    t_nonspec();
    t_replay_squash();
    t_full();
    t_age_order();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule